// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block gathers 72 level-sensitive interrupt lines into one processor interrupt (IRQ) and one fast interrupt (FIQ). The lines sit in three groups: a basic group of 8 and two wide groups of 32 each. Software masks each line through per-group registers: a write-one-to-set enable register and a write-one-to-clear disable register. It reads a pending word for each group that shows the lines that are both high and unmasked.

The basic pending word is the first thing a handler reads. Besides the 8 basic lines it carries one summary bit per wide group and shortcut copies of eleven frequently serviced wide-group lines. A handler can therefore often find the source without a second read. A line that has a shortcut does not raise its group's summary bit. Any single line can also be routed to the FIQ output through a control register that holds a 7-bit line index and an enable bit. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `banked_irq_ctrl`

## Requirements
- R1: While rst_n is low on a rising clock edge, all three enable masks and the FIQ control register clear to zero, so both outputs stay low whatever the source lines do.
- R2: A write to an enable register (wide group 1 at 0x10, wide group 2 at 0x14, basic at 0x18) sets every mask bit written as 1 and leaves every bit written as 0 unchanged. Reading an enable register returns the current mask.
- R3: A write to a disable register (group 1 at 0x1C, group 2 at 0x20, basic at 0x24) clears every mask bit written as 1 and leaves the others unchanged. Reading a disable register returns the current mask.
- R4: The wide pending words (group 1 at 0x04, group 2 at 0x08) read source AND mask, combinationally and without latching: a bit clears as soon as its line drops.
- R5: Bits 7:0 of the basic pending word (0x00) are the basic lines AND the basic mask.
- R6: Basic pending bits 14:10 copy group-1 pending bits 7, 9, 10, 18, 19 (in that order), and bits 20:15 copy group-2 pending bits 21, 22, 23, 24, 25, 30. A shortcut is masked only through its own group's mask.
- R7: Basic pending bit 8 (bit 9) is the OR of the pending bits of group 1 (group 2) that have no shortcut.
- R8: Basic enable and disable writes affect only the 8 basic mask bits. Summary and shortcut bits keep their values through them.
- R9: The IRQ output is high exactly when the basic pending word is non-zero.
- R10: The FIQ control register (0x0C) holds a line index in bits 6:0 (0–31 group 1, 32–63 group 2, 64–71 basic) and an enable in bit 7. The FIQ output is the enable AND the raw selected line, and an index above 71 selects nothing.
- R11: FIQ routing ignores the mask of the selected line. A routed line that is unmasked still drives IRQ as well.
- R12: FIQ control bits 31:8, basic pending bits 31:21 and any unmapped or unaligned address read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_basic | input | 8 | Basic group level lines |
| src_wide1 | input | 32 | Wide group 1 level lines |
| src_wide2 | input | 32 | Wide group 2 level lines |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Processor interrupt |
| fiq_out | output | 1 | Fast interrupt |

## Verification
The hardest situation to reach is a basic pending word where a wide group has both shortcut and non-shortcut lines pending at once, while its basic mask is being rewritten. Only then does a wrong summary or shortcut mapping, or a leak from the basic mask, show up. The vector table drives mixed shortcut and plain lines in each wide group with every mask open. The directed part then writes all ones to the basic enable and disable registers while group-1 lines are pending, and reads the basic word after each write. FIQ selection is probed at one index in each group and at an index past the last line with every line high.

// File: rtl/banked_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the banked interrupt aggregator: group sizes,
// register byte offsets and the shortcut line lists. Assumes 32-bit words.
package banked_irq_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int BASIC_N   = 8;
    localparam int WIDE_N    = 32;
    localparam int FIQ_IDX_W = 7;
    localparam int FIQ_CTL_W = FIQ_IDX_W + 1;
    localparam int SC1_N     = 5;
    localparam int SC2_N     = 6;
    localparam int ALL_N     = 2 * WIDE_N + BASIC_N;
    localparam int SUM1_BIT  = BASIC_N;
    localparam int SUM2_BIT  = BASIC_N + 1;
    localparam int SC1_LSB   = BASIC_N + 2;
    localparam int SC2_LSB   = SC1_LSB + SC1_N;
    localparam int BASIC_USED = SC2_LSB + SC2_N;

    // Byte offsets; software decodes these, so they are fixed.
    localparam logic [ADDR_W-1:0] OFS_PEND0 = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND1 = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND2 = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_FIQ   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_EN1   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_EN2   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_EN0   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DIS1  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_DIS2  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_DIS0  = 6'h24;

    // Group-1 line mirrored at shortcut position k.
    function automatic int sc1_src(input int k);
        case (k)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            default: return 19;
        endcase
    endfunction

    // Group-2 line mirrored at shortcut position k.
    function automatic int sc2_src(input int k);
        case (k)
            0:       return 21;
            1:       return 22;
            2:       return 23;
            3:       return 24;
            4:       return 25;
            default: return 30;
        endcase
    endfunction

    function automatic logic [WIDE_N-1:0] sc1_mask();
        logic [WIDE_N-1:0] m;
        m = '0;
        for (int k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
        return m;
    endfunction

    function automatic logic [WIDE_N-1:0] sc2_mask();
        logic [WIDE_N-1:0] m;
        m = '0;
        for (int k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
        return m;
    endfunction

    localparam logic [WIDE_N-1:0] SC1_MASK = sc1_mask();
    localparam logic [WIDE_N-1:0] SC2_MASK = sc2_mask();
endpackage

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
// One interrupt group: a mask register updated by set and clear strobes,
// and the masked pending vector. Assumes set and clear never coincide
// (they decode different addresses); set wins if they do.
module irq_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] src,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend
);
    // Mask register: write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (set_we) en_q <= en_q | wdata;
        else if (clr_we) en_q <= en_q & ~wdata;
    end

    // Level pending: no storage, follows the lines directly.
    always_comb pend = src & en_q;
endmodule

// File: rtl/irq_basic_word.sv
`timescale 1ns/1ps
// Builds the basic pending word: basic lines, one summary bit per wide
// group (non-shortcut lines only) and shortcut copies of selected lines.
// Assumes inputs are already masked.
module irq_basic_word
    import banked_irq_pkg::*;
(
    input  logic [BASIC_N-1:0] pend0,
    input  logic [WIDE_N-1:0]  pend1,
    input  logic [WIDE_N-1:0]  pend2,
    output logic [DATA_W-1:0]  word
);
    logic [SC1_N-1:0] sc1_bits;
    logic [SC2_N-1:0] sc2_bits;
    logic             sum1, sum2;

    for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
        assign sc1_bits[k] = pend1[sc1_src(k)];
    end
    for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
        assign sc2_bits[k] = pend2[sc2_src(k)];
    end

    // Summary bits: lines with a shortcut are left out.
    always_comb begin
        sum1 = |(pend1 & ~SC1_MASK);
        sum2 = |(pend2 & ~SC2_MASK);
    end

    // Pack the word; bits above the shortcut fields are zero.
    always_comb begin
        word = '0;
        word[BASIC_N-1:0]           = pend0;
        word[SUM1_BIT]              = sum1;
        word[SUM2_BIT]              = sum2;
        word[SC2_LSB-1:SC1_LSB]     = sc1_bits;
        word[BASIC_USED-1:SC2_LSB]  = sc2_bits;
    end
endmodule

// File: rtl/fiq_route.sv
`timescale 1ns/1ps
// Fast-interrupt routing: holds a line index and enable, and selects the
// raw line (mask ignored). Line order is group 1, group 2, then basic.
module fiq_route
    import banked_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [FIQ_CTL_W-1:0] wdata,
    input  logic [ALL_N-1:0]     src_all,
    output logic [FIQ_CTL_W-1:0] ctrl_q,
    output logic                 fiq
);
    logic sel_line;

    // Control register: index in the low bits, enable on top.
    always_ff @(posedge clk) begin
        if (!rst_n)  ctrl_q <= '0;
        else if (we) ctrl_q <= wdata;
    end

    // Pick the indexed line; indices past the last line pick nothing.
    always_comb begin
        sel_line = 1'b0;
        for (int i = 0; i < ALL_N; i++)
            if (ctrl_q[FIQ_IDX_W-1:0] == FIQ_IDX_W'(i)) sel_line = src_all[i];
    end

    // Gate by the enable bit.
    always_comb fiq = ctrl_q[FIQ_CTL_W-1] & sel_line;
endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
// Top of the banked interrupt aggregator: address decode, three mask
// groups, basic word builder, FIQ router and read mux. Assumes level
// lines already synchronous to clk and a single-cycle write strobe.
module banked_irq_ctrl
    import banked_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BASIC_N-1:0]  src_basic,
    input  logic [WIDE_N-1:0]   src_wide1,
    input  logic [WIDE_N-1:0]   src_wide2,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_out,
    output logic                fiq_out
);
    logic [BASIC_N-1:0]   en0_q, pend0;
    logic [WIDE_N-1:0]    en1_q, pend1, en2_q, pend2;
    logic [DATA_W-1:0]    basic_word;
    logic [FIQ_CTL_W-1:0] fiq_ctrl_q;
    logic                 we_en0, we_en1, we_en2, we_dis0, we_dis1, we_dis2, we_fiq;

    // Write decode on the full byte address.
    always_comb begin
        we_en0  = bus_wr && (bus_addr == OFS_EN0);
        we_en1  = bus_wr && (bus_addr == OFS_EN1);
        we_en2  = bus_wr && (bus_addr == OFS_EN2);
        we_dis0 = bus_wr && (bus_addr == OFS_DIS0);
        we_dis1 = bus_wr && (bus_addr == OFS_DIS1);
        we_dis2 = bus_wr && (bus_addr == OFS_DIS2);
        we_fiq  = bus_wr && (bus_addr == OFS_FIQ);
    end

    irq_mask_bank #(.W(BASIC_N)) u_grp0 (
        .clk(clk), .rst_n(rst_n), .set_we(we_en0), .clr_we(we_dis0),
        .wdata(bus_wdata[BASIC_N-1:0]), .src(src_basic), .en_q(en0_q), .pend(pend0)
    );
    irq_mask_bank #(.W(WIDE_N)) u_grp1 (
        .clk(clk), .rst_n(rst_n), .set_we(we_en1), .clr_we(we_dis1),
        .wdata(bus_wdata[WIDE_N-1:0]), .src(src_wide1), .en_q(en1_q), .pend(pend1)
    );
    irq_mask_bank #(.W(WIDE_N)) u_grp2 (
        .clk(clk), .rst_n(rst_n), .set_we(we_en2), .clr_we(we_dis2),
        .wdata(bus_wdata[WIDE_N-1:0]), .src(src_wide2), .en_q(en2_q), .pend(pend2)
    );

    irq_basic_word u_word (
        .pend0(pend0), .pend1(pend1), .pend2(pend2), .word(basic_word)
    );

    fiq_route u_fiq (
        .clk(clk), .rst_n(rst_n), .we(we_fiq), .wdata(bus_wdata[FIQ_CTL_W-1:0]),
        .src_all({src_basic, src_wide2, src_wide1}),
        .ctrl_q(fiq_ctrl_q), .fiq(fiq_out)
    );

    // IRQ: anything showing in the basic word.
    always_comb irq_out = |basic_word;

    // Read mux; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PEND0:          bus_rdata = basic_word;
            OFS_PEND1:          bus_rdata = pend1;
            OFS_PEND2:          bus_rdata = pend2;
            OFS_FIQ:            bus_rdata = DATA_W'(fiq_ctrl_q);
            OFS_EN1, OFS_DIS1:  bus_rdata = en1_q;
            OFS_EN2, OFS_DIS2:  bus_rdata = en2_q;
            OFS_EN0, OFS_DIS0:  bus_rdata = DATA_W'(en0_q);
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for banked_irq_ctrl, attached by bind. Observes ports
// and the mask, summary and control state of the submodules.
module banked_irq_ctrl_chk
    import banked_irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [BASIC_N-1:0]  src_basic,
    input logic [WIDE_N-1:0]   src_wide1,
    input logic [WIDE_N-1:0]   src_wide2,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                irq_out,
    input logic                fiq_out,
    input logic [BASIC_N-1:0]  en0,
    input logic [WIDE_N-1:0]   en1,
    input logic [WIDE_N-1:0]   en2,
    input logic                sum1,
    input logic                sum2,
    input logic                sc_first,
    input logic                fiq_en
);
    // R1: reset clears all masks and FIQ enable
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (en0 == '0 && en1 == '0 && en2 == '0 && !fiq_en));

    // R2: enable write sets the written ones
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN1) |=> ((en1 & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: disable write clears the written ones
    a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIS2) |=> ((en2 & $past(bus_wdata)) == '0));

    // R6: first group-1 shortcut follows line 7 and its own mask
    a_r6_shortcut_map: assert property (@(posedge clk) disable iff (!rst_n)
        sc_first == (src_wide1[7] && en1[7]));

    // R7: summary bits need a non-shortcut unmasked line
    a_r7_summary_src: assert property (@(posedge clk) disable iff (!rst_n)
        (sum1 |-> |(src_wide1 & en1 & ~SC1_MASK)) and (sum2 |-> |(src_wide2 & en2 & ~SC2_MASK)));

    // R8: basic mask writes leave the wide masks alone
    a_r8_basic_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_EN0 || bus_addr == OFS_DIS0)) |=> ($stable(en1) && $stable(en2)));

    // R9: IRQ needs some line high
    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|src_basic || |src_wide1 || |src_wide2));

    // R11: FIQ needs its enable bit
    a_r11_fiq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_out |-> fiq_en);
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .src_basic(src_basic), .src_wide1(src_wide1),
    .src_wide2(src_wide2), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irq_out(irq_out), .fiq_out(fiq_out),
    .en0(en0_q), .en1(en1_q), .en2(en2_q),
    .sum1(basic_word[8]), .sum2(basic_word[9]), .sc_first(basic_word[10]),
    .fiq_en(fiq_ctrl_q[7])
);

// File: tb/banked_irq_ctrl_bench.sv
`timescale 1ns/1ps
module banked_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_basic = '0;
    logic [31:0] src_wide1 = '0;
    logic [31:0] src_wide2 = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, fiq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    banked_irq_ctrl u_banked_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_basic(src_basic), .src_wide1(src_wide1),
        .src_wide2(src_wide2), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    typedef struct packed {
        logic [7:0]  b;
        logic [31:0] w1;
        logic [31:0] w2;
        logic [31:0] exp_word;
    } vec_t;

    // All masks open; expected basic word from R5/R6/R7.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        '{8'h05, 32'h0000_0000, 32'h0000_0000, 32'h0000_0005},
        '{8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
        '{8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
        '{8'h00, 32'h000C_0600, 32'h0000_0000, 32'h0000_7800},
        '{8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
        '{8'h00, 32'h0000_0000, 32'h03E0_0000, 32'h000F_8000},
        '{8'h00, 32'h0000_0000, 32'h0000_0001, 32'h0000_0200},
        '{8'h00, 32'h0000_0080, 32'h0020_0001, 32'h0000_8600},
        '{8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h001F_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        logic [31:0] r;
        // R1: reset state with lines high
        src_basic = 8'hFF; src_wide1 = '1; src_wide2 = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
        chk("R1 fiq", {31'b0, fiq_out}, 32'h0);
        rd(6'h10, r); chk("R1 en1", r, 32'h0);
        rd(6'h14, r); chk("R1 en2", r, 32'h0);
        rd(6'h18, r); chk("R1 en0", r, 32'h0);
        rd(6'h0C, r); chk("R1 fiqctl", r, 32'h0);
        src_basic = '0; src_wide1 = '0; src_wide2 = '0;

        // R2: set semantics
        wr(6'h10, 32'h0000_00F0);
        wr(6'h10, 32'h0000_0001);
        rd(6'h10, r); chk("R2 en1 set", r, 32'h0000_00F1);
        rd(6'h1C, r); chk("R3 dis1 readback", r, 32'h0000_00F1);
        // R3: clear semantics
        wr(6'h1C, 32'h0000_0030);
        rd(6'h1C, r); chk("R3 en1 clear", r, 32'h0000_00C1);

        // R4: level pending
        src_wide1 = 32'h0000_00FF;
        rd(6'h04, r); chk("R4 pend1", r, 32'h0000_00C1);
        rd(6'h00, r); chk("R7 basic mixed", r, 32'h0000_0500);
        chk("R9 irq mixed", {31'b0, irq_out}, 32'h1);
        src_wide1 = '0;
        rd(6'h04, r); chk("R4 pend1 drop", r, 32'h0);
        chk("R9 irq drop", {31'b0, irq_out}, 32'h0);

        // R8: basic mask writes do not touch summary/shortcut bits
        src_wide1 = 32'h0000_0081;
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, r); chk("R8 en0 width", r, 32'h0000_00FF);
        rd(6'h00, r); chk("R8 after en0", r, 32'h0000_0500);
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h24, r); chk("R8 en0 cleared", r, 32'h0);
        rd(6'h00, r); chk("R8 after dis0", r, 32'h0000_0500);
        // R6: shortcut masked by its own group
        wr(6'h1C, 32'h0000_0080);
        rd(6'h00, r); chk("R6 own mask", r, 32'h0000_0100);
        src_wide1 = '0;

        // Vector table, all masks open (R5, R6, R7, R9, R4)
        wr(6'h18, 32'h0000_00FF);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h14, 32'hFFFF_FFFF);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            src_basic = VECS[i].b; src_wide1 = VECS[i].w1; src_wide2 = VECS[i].w2;
            rd(6'h00, r); chk("R5 R6 R7 basic word", r, VECS[i].exp_word);
            chk("R9 irq", {31'b0, irq_out}, {31'b0, VECS[i].exp_word != 0});
            rd(6'h04, r); chk("R4 pend1", r, VECS[i].w1);
            rd(6'h08, r); chk("R4 pend2", r, VECS[i].w2);
        end
        src_basic = '0; src_wide1 = '0; src_wide2 = '0;

        // R10/R11: FIQ routing with all masks closed
        wr(6'h24, 32'hFFFF_FFFF);
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h0C, 32'h0000_0085);
        src_wide1 = 32'h0000_0020;
        #1;
        chk("R11 fiq masked line", {31'b0, fiq_out}, 32'h1);
        chk("R11 irq stays low", {31'b0, irq_out}, 32'h0);
        src_wide1 = '0;
        #1;
        chk("R10 fiq level drop", {31'b0, fiq_out}, 32'h0);
        wr(6'h0C, 32'h0000_00A3);
        src_wide2 = 32'h0000_0008;
        #1; chk("R10 idx 35", {31'b0, fiq_out}, 32'h1);
        src_wide2 = 32'hFFFF_FFF7;
        #1; chk("R10 idx 35 other lines", {31'b0, fiq_out}, 32'h0);
        src_wide2 = '0;
        wr(6'h0C, 32'h0000_00C2);
        src_basic = 8'h04;
        #1; chk("R10 idx 66", {31'b0, fiq_out}, 32'h1);
        wr(6'h0C, 32'h0000_00E4);
        src_basic = '1; src_wide1 = '1; src_wide2 = '1;
        #1; chk("R10 idx 100", {31'b0, fiq_out}, 32'h0);
        wr(6'h0C, 32'hFFFF_FF05);
        rd(6'h0C, r); chk("R12 fiqctl upper", r, 32'h0000_0005);
        chk("R10 fiq disabled", {31'b0, fiq_out}, 32'h0);

        // R12: unmapped and unaligned reads
        rd(6'h28, r); chk("R12 unmapped 0x28", r, 32'h0);
        rd(6'h3C, r); chk("R12 unmapped 0x3C", r, 32'h0);
        rd(6'h05, r); chk("R12 unaligned", r, 32'h0);

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule